// File: doc/BRIEF.md
# Power Mode and Clock-Divider Controller

This block sets the operating mode of a small processor core and turns one fast oscillator clock into clock-enable pulses for the CPU and for the peripherals. A software-written control register holds a slow-mode enable and a two-bit rate select. When slow mode is on, the master rate becomes the oscillator rate divided by 2, 4, 8 or 16. A wait strobe stops the CPU and leaves the peripherals running. A halt strobe stops both. Whether a halt becomes Active-halt or full Halt depends on whether the oscillator is to keep running.

Everything runs in the oscillator clock domain. The outputs are enables, not derived clocks. A new rate setting is taken up only at the end of a divider period, so no enable pulse ever comes early. A wake-up interrupt brings the block back from any stopped mode. The reported mode is a 3-bit code.

Top module: `pwrModeCtrl`

## Requirements
- R1: After reset the reported mode is Run (code 0), and `cpuClkEn` and `perClkEn` are high on every oscillator cycle.
- R2: A write with `regWrEn` loads `regWrData`: bit 2 enables slow mode and bits 1:0 select the divisor, 00=/2, 01=/4, 10=/8, 11=/16. With slow mode active, the mode code is 1 (Slow), and `cpuClkEn` and `perClkEn` pulse together for one cycle once every 2<<select cycles.
- R3: A new enable or select is applied only at the end of the current divider period. The interval that is running when a write lands keeps the old length, and the following intervals use the new length.
- R4: `waitReq` in Run enters Wait (code 2). `cpuClkEn` stays low and `perClkEn` stays high every cycle.
- R5: `waitReq` in Slow enters Slow-Wait (code 3). `cpuClkEn` stays low and `perClkEn` keeps the divided period.
- R6: `haltReq` with `oscKeep` high enters Active-halt (code 4). Both enables are low and `aliveTick` stays high.
- R7: `haltReq` with `oscKeep` low enters Halt (code 5). Both enables and `aliveTick` are low.
- R8: When `haltReq` and `waitReq` come in the same cycle, the halt request wins.
- R9: `wakeIrq` returns Wait to Run and Slow-Wait to Slow. From either halt mode it returns to Slow if the slow-enable bit holds 1 at that time, and to Run otherwise. This includes a value written during the halt.
- R10: `waitReq` and `haltReq` have no effect outside Run and Slow, and `wakeIrq` has no effect in Run or Slow.
- R11: The mode output only takes the codes 0 to 5 listed above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Active-low reset |
| regWrEn | input | 1 | Control register write strobe |
| regWrData | input | 3 | Control register data: bit 2 slow enable, bits 1:0 select |
| waitReq | input | 1 | Wait request strobe |
| haltReq | input | 1 | Halt request strobe |
| oscKeep | input | 1 | Keep oscillator running during halt |
| wakeIrq | input | 1 | Wake-up interrupt |
| cpuClkEn | output | 1 | CPU clock enable pulse |
| perClkEn | output | 1 | Peripheral clock enable pulse |
| aliveTick | output | 1 | Always-on tick, high unless in Halt |
| modeState | output | 3 | Current mode code |

## Verification
On every cycle the assertions check these properties: each enable is gated by the mode, the CPU enable never fires without the peripheral enable, the always-on tick matches the two halt modes, every mode transition caused by a request or a wake-up lands in the correct mode, Halt holds until woken, and the mode code stays legal. Other behaviour needs the bench's scenarios. These cover the divided periods for each select value, the old-period-then-new-period sequence when a write lands partway through a period, and the peripheral period inside Slow-Wait. They also cover waking from a halt into a rate written while the counter was frozen. Random sequences of writes, requests and wake-ups are compared against a mode model.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  localparam int SEL_W  = 2;
  localparam int CFG_W  = SEL_W + 1;
  localparam int CNT_W  = 1 << SEL_W;
  localparam int MODE_W = 3;

  typedef struct packed {
    logic             slowEn;
    logic [SEL_W-1:0] sel;
  } divCfg_t;

  typedef struct packed {
    logic hold;
    logic reload;
  } divStrobe_t;

  typedef enum logic [1:0] {
    PH_ACTIVE = 2'd0,
    PH_WAIT   = 2'd1,
    PH_AHALT  = 2'd2,
    PH_HALT   = 2'd3
  } phase_t;

  localparam logic [MODE_W-1:0] MODE_RUN   = 3'd0;
  localparam logic [MODE_W-1:0] MODE_SLOW  = 3'd1;
  localparam logic [MODE_W-1:0] MODE_WAIT  = 3'd2;
  localparam logic [MODE_W-1:0] MODE_SWAIT = 3'd3;
  localparam logic [MODE_W-1:0] MODE_AHALT = 3'd4;
  localparam logic [MODE_W-1:0] MODE_HALT  = 3'd5;
endpackage

// File: rtl/pwrClkDiv.sv
module pwrClkDiv
  import pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  divCfg_t    wrCfg,
  input  divStrobe_t strobe,
  output logic       termCnt,
  output logic       actSlow
);
  divCfg_t          ctlReg;
  logic [SEL_W-1:0] actSel;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   divisor;
  logic [CNT_W-1:0] termVal;
  logic             atEnd;

  // divisor = 2 << select, compared against (divisor - 1)
  always_comb begin
    divisor = (CNT_W+1)'(2) << actSel;
    termVal = CNT_W'(divisor - (CNT_W+1)'(1));
    atEnd   = !actSlow || (cnt == termVal);
    termCnt = !strobe.hold && atEnd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlReg  <= '0;
      actSlow <= 1'b0;
      actSel  <= '0;
      cnt     <= '0;
    end else begin
      if (regWrEn) ctlReg <= wrCfg;
      if (strobe.reload) begin
        cnt     <= '0;
        actSlow <= ctlReg.slowEn;
        actSel  <= ctlReg.sel;
      end else if (!strobe.hold) begin
        if (atEnd) begin
          cnt     <= '0;
          actSlow <= ctlReg.slowEn;
          actSel  <= ctlReg.sel;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/pwrModeFsm.sv
module pwrModeFsm
  import pwr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              waitReq,
  input  logic              haltReq,
  input  logic              oscKeep,
  input  logic              wakeIrq,
  input  logic              termCnt,
  input  logic              actSlow,
  output divStrobe_t        strobe,
  output logic              cpuClkEn,
  output logic              perClkEn,
  output logic              aliveTick,
  output logic [MODE_W-1:0] modeState
);
  phase_t phase, phaseNxt;

  always_comb begin
    phaseNxt = phase;
    case (phase)
      PH_ACTIVE: begin
        if (haltReq)      phaseNxt = oscKeep ? PH_AHALT : PH_HALT;
        else if (waitReq) phaseNxt = PH_WAIT;
      end
      PH_WAIT, PH_AHALT, PH_HALT: begin
        if (wakeIrq) phaseNxt = PH_ACTIVE;
      end
      default: phaseNxt = PH_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_ACTIVE;
    else       phase <= phaseNxt;
  end

  always_comb begin
    strobe.hold   = (phase == PH_HALT);
    strobe.reload = ((phase == PH_HALT) || (phase == PH_AHALT)) && wakeIrq;
    cpuClkEn      = (phase == PH_ACTIVE) && termCnt;
    perClkEn      = ((phase == PH_ACTIVE) || (phase == PH_WAIT)) && termCnt;
    aliveTick     = (phase != PH_HALT);
    case (phase)
      PH_ACTIVE: modeState = actSlow ? MODE_SLOW : MODE_RUN;
      PH_WAIT:   modeState = actSlow ? MODE_SWAIT : MODE_WAIT;
      PH_AHALT:  modeState = MODE_AHALT;
      default:   modeState = MODE_HALT;
    endcase
  end
endmodule

// File: rtl/pwrModeCtrl.sv
module pwrModeCtrl
  import pwr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [CFG_W-1:0]  regWrData,
  input  logic              waitReq,
  input  logic              haltReq,
  input  logic              oscKeep,
  input  logic              wakeIrq,
  output logic              cpuClkEn,
  output logic              perClkEn,
  output logic              aliveTick,
  output logic [MODE_W-1:0] modeState
);
  divStrobe_t strobe;
  logic       termCnt;
  logic       actSlow;

  pwrClkDiv uDiv (
    .clk     (clk),
    .rstN    (rstN),
    .regWrEn (regWrEn),
    .wrCfg   (divCfg_t'(regWrData)),
    .strobe  (strobe),
    .termCnt (termCnt),
    .actSlow (actSlow)
  );

  pwrModeFsm uFsm (
    .clk       (clk),
    .rstN      (rstN),
    .waitReq   (waitReq),
    .haltReq   (haltReq),
    .oscKeep   (oscKeep),
    .wakeIrq   (wakeIrq),
    .termCnt   (termCnt),
    .actSlow   (actSlow),
    .strobe    (strobe),
    .cpuClkEn  (cpuClkEn),
    .perClkEn  (perClkEn),
    .aliveTick (aliveTick),
    .modeState (modeState)
  );
endmodule

// File: rtl/pwrModeCtrl_chk.sv
module pwrModeCtrl_chk
  import pwr_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              waitReq,
  input logic              haltReq,
  input logic              oscKeep,
  input logic              wakeIrq,
  input logic              cpuClkEn,
  input logic              perClkEn,
  input logic              aliveTick,
  input logic [MODE_W-1:0] modeState
);
  AST_LEGAL_MODE: assert property (@(posedge clk) disable iff (!rstN)
    modeState <= MODE_HALT); // R11
  AST_CPU_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    cpuClkEn |-> (modeState <= MODE_SLOW)); // R4
  AST_PER_GATED: assert property (@(posedge clk) disable iff (!rstN)
    perClkEn |-> (modeState <= MODE_SWAIT)); // R6
  AST_CPU_WITH_PER: assert property (@(posedge clk) disable iff (!rstN)
    cpuClkEn |-> perClkEn); // R2
  AST_TICK_AHALT: assert property (@(posedge clk) disable iff (!rstN)
    (modeState == MODE_AHALT) |-> aliveTick); // R6
  AST_TICK_HALT: assert property (@(posedge clk) disable iff (!rstN)
    (modeState == MODE_HALT) |-> !aliveTick); // R7
  AST_WAIT_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    ((modeState <= MODE_SLOW) && waitReq && !haltReq) |=>
      ((modeState == MODE_WAIT) || (modeState == MODE_SWAIT))); // R4
  AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    ((modeState <= MODE_SLOW) && haltReq && !oscKeep) |=> (modeState == MODE_HALT)); // R8
  AST_AHALT_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    ((modeState <= MODE_SLOW) && haltReq && oscKeep) |=> (modeState == MODE_AHALT)); // R6
  AST_WAKE_RETURN: assert property (@(posedge clk) disable iff (!rstN)
    ((modeState >= MODE_WAIT) && wakeIrq) |=> (modeState <= MODE_SLOW)); // R9
  AST_HALT_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    ((modeState == MODE_HALT) && !wakeIrq) |=> (modeState == MODE_HALT)); // R10
endmodule

bind pwrModeCtrl pwrModeCtrl_chk uChk (.*);

// File: tb/pwrModeCtrl_test.sv
module pwrModeCtrl_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [2:0] regWrData = '0;
  logic       waitReq = 1'b0, haltReq = 1'b0, oscKeep = 1'b0, wakeIrq = 1'b0;
  logic       cpuClkEn, perClkEn, aliveTick;
  logic [2:0] modeState;

  int  nChk = 0;
  int  nFail = 0;
  bit  finished = 1'b0;

  always #2 clk = ~clk;

  pwrModeCtrl uut (.*);

  task automatic chk(string req, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic sig(int which);
    return (which == 0) ? cpuClkEn : perClkEn;
  endfunction

  function automatic int expMode(int ph, bit slow);
    case (ph)
      0: return slow ? 1 : 0;
      1: return slow ? 3 : 2;
      2: return 4;
      default: return 5;
    endcase
  endfunction

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeCfg(bit en, int sel);
    @(negedge clk);
    regWrEn = 1'b1; regWrData = {en, 2'(sel)};
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // 0 wait, 1 halt, 2 wake, 3 wait+halt
  task automatic strobe(int which);
    @(negedge clk);
    waitReq = (which == 0) || (which == 3);
    haltReq = (which == 1) || (which == 3);
    wakeIrq = (which == 2);
    @(negedge clk);
    waitReq = 1'b0; haltReq = 1'b0; wakeIrq = 1'b0;
  endtask

  task automatic waitPulse(int which);
    do @(negedge clk); while (!sig(which));
  endtask

  task automatic measure(int which, output int n);
    waitPulse(which);
    n = 0;
    do begin @(negedge clk); n++; end while (!sig(which));
  endtask

  task automatic countPulses(int which, int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (sig(which)) n++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    int n;
    int ph;
    bit slow;
    void'($urandom(32'h5eed_0042));
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    // R1 reset state
    chk("R1 mode", modeState, 0);
    countPulses(0, 6, n); chk("R1 cpu pulses", n, 6);
    countPulses(1, 6, n); chk("R1 per pulses", n, 6);

    // R2 every divisor
    for (int s = 0; s < 4; s++) begin
      writeCfg(1'b1, s); cyc(40);
      chk("R2 mode slow", modeState, 1);
      measure(0, n); chk("R2 cpu period", n, 2 << s);
      measure(1, n); chk("R2 per period", n, 2 << s);
    end

    // R3 change lands at the end of a period: /16 then /2
    waitPulse(1);
    regWrEn = 1'b1; regWrData = 3'b100;
    n = 0;
    do begin
      @(negedge clk); n++; regWrEn = 1'b0;
    end while (!perClkEn);
    chk("R3 old interval", n, 16);
    n = 0;
    do begin @(negedge clk); n++; end while (!perClkEn);
    chk("R3 new interval", n, 2);

    // R5 slow-wait at /4
    writeCfg(1'b1, 1); cyc(40);
    strobe(0);
    chk("R5 mode", modeState, 3);
    measure(1, n); chk("R5 per period", n, 4);
    countPulses(0, 20, n); chk("R5 cpu stopped", n, 0);
    strobe(2);
    chk("R9 slow-wait to slow", modeState, 1);
    strobe(2);
    chk("R10 wake ignored in slow", modeState, 1);

    // R4 wait from run
    writeCfg(1'b0, 0); cyc(40);
    chk("R2 back to run", modeState, 0);
    strobe(0);
    chk("R4 mode", modeState, 2);
    countPulses(1, 8, n); chk("R4 per every cycle", n, 8);
    countPulses(0, 8, n); chk("R4 cpu stopped", n, 0);
    strobe(1);
    chk("R10 halt ignored in wait", modeState, 2);
    strobe(2);
    chk("R9 wait to run", modeState, 0);

    // R6 active-halt
    oscKeep = 1'b1;
    strobe(1);
    chk("R6 mode", modeState, 4);
    chk("R6 tick", aliveTick, 1);
    countPulses(1, 10, n); chk("R6 per stopped", n, 0);
    countPulses(0, 10, n); chk("R6 cpu stopped", n, 0);
    strobe(0);
    chk("R10 wait ignored in active-halt", modeState, 4);
    strobe(2);
    chk("R9 active-halt to run", modeState, 0);

    // R7 halt, write during halt, wake into slow
    oscKeep = 1'b0;
    strobe(1);
    chk("R7 mode", modeState, 5);
    chk("R7 tick", aliveTick, 0);
    countPulses(1, 10, n); chk("R7 per stopped", n, 0);
    writeCfg(1'b1, 1);
    chk("R7 still halted", modeState, 5);
    strobe(2);
    chk("R9 halt to slow", modeState, 1);
    measure(0, n); chk("R9 period after wake", n, 4);

    // R8 both requests
    strobe(3);
    chk("R8 halt wins", modeState, 5);
    writeCfg(1'b0, 0);
    strobe(2);
    chk("R9 halt to run", modeState, 0);

    // random sequences against a mode model
    ph = 0; slow = 1'b0;
    for (int it = 0; it < 80; it++) begin
      int op;
      op = $urandom_range(0, 4);
      case (op)
        0: begin
          bit en; int s;
          en = 1'($urandom_range(0, 1)); s = $urandom_range(0, 3);
          writeCfg(en, s); slow = en;
        end
        1: begin strobe(0); if (ph == 0) ph = 1; end
        2: begin
          oscKeep = 1'($urandom_range(0, 1));
          strobe(1);
          if (ph == 0) ph = oscKeep ? 2 : 3;
        end
        3: begin strobe(2); ph = 0; end
        default: begin
          oscKeep = 1'($urandom_range(0, 1));
          strobe(3);
          if (ph == 0) ph = oscKeep ? 2 : 3;
        end
      endcase
      cyc(40);
      chk("R9 R10 random mode", modeState, expMode(ph, slow));
      chk("R7 random tick", aliveTick, (ph == 3) ? 0 : 1);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule